// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block is a single channel of a hardware breakpoint unit. It watches every completed bus cycle on the monitor inputs and compares three of the cycle's properties against a programmed control register: whether the cycle is an instruction fetch or a data access, whether it reads or writes, and the operand size. When every enabled condition agrees, it raises a one-clock break interrupt request and sets a sticky hit flag.

Software programs the channel through one 8-bit control register. A write takes effect for the bus cycles that follow it. The same register reads back the fields and the hit flag. A cycle-kind or direction field of 00 turns the whole channel off. A size field of 00 only drops the size condition. Instruction fetches are always compared as word size, whatever size code the bus shows. No correction is applied for them, so software must choose a size setting with the low bit clear to break on fetches.

Top module: `brk_cycle_match`

## Requirements
- R1: After reset the control register reads 8'h0C: cycle-kind 00, direction 11, size 00, hit flag 0. The interrupt request is low.
- R2: The cycle-kind field sits at bits [1:0]. 01 matches instruction fetches (bus_ifetch=1), 10 matches data accesses (bus_ifetch=0), 11 matches both, and 00 blocks every request from the channel.
- R3: The direction field sits at bits [3:2]. 01 matches reads (bus_write=0), 10 matches writes (bus_write=1), 11 matches both, and 00 blocks every request from the channel.
- R4: The size field sits at bits [5:4]. 00 leaves size out of the match; 01, 10 and 11 require byte, word or longword respectively.
- R5: An instruction fetch is compared as word size (10), whatever bus_size shows. With the size field at 01 or 11, a fetch never matches.
- R6: A data access is compared using bus_size as its operand size. The codes are 01 byte, 10 word and 11 longword.
- R7: The request brk_irq is high for exactly the one clock that follows an edge at which bus_valid was 1 and all conditions matched. It is low after any other edge.
- R8: Bit 7 is a sticky hit flag. It is set at the same edge that raises brk_irq. Writing 0 to bit 7 clears it, and writing 1 leaves it unchanged. A hit in the same cycle as a clearing write leaves it set.
- R9: A register write at one edge controls the bus cycles sampled from the next edge on. A bus cycle sampled at the same edge as the write uses the old settings. Bits [5:0] read back as written.
- R10: Bit 6 ignores writes and always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data, including the hit flag |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size code: 01 byte, 10 word, 11 longword |
| brk_irq | output | 1 | Single-cycle break interrupt request |

## Verification
The bench drives fetches that show a longword bus size while the size field asks for word. A design that compared the raw bus size there would miss the break, and it would wrongly break when the field asks for longword. It programs each of the two enable fields to 00 while the other fields allow everything, to catch a design that treats 00 as "don't care". It writes the register and presents a bus cycle at the same edge, which separates old-setting from new-setting behaviour. It also lines up a hit with a flag-clearing write, to show which of the two wins.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int REG_W    = 8;
  localparam int FLD_W    = 2;
  localparam int FLAG_BIT = REG_W - 1;
  localparam int RSV_BIT  = REG_W - 2;

  localparam logic [FLD_W-1:0] SZ_ANY  = 2'b00;
  localparam logic [FLD_W-1:0] SZ_WORD = 2'b10;
  localparam logic [FLD_W-1:0] FLD_OFF = 2'b00;

  typedef struct packed {
    logic [FLD_W-1:0] size;   // bits [5:4]
    logic [FLD_W-1:0] dir;    // bits [3:2]
    logic [FLD_W-1:0] kind;   // bits [1:0]
  } brk_cfg_t;

  localparam brk_cfg_t CFG_RESET = '{size: 2'b00, dir: 2'b11, kind: 2'b00};
endpackage

// File: rtl/brk_ctrl_reg.sv
module brk_ctrl_reg
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             hit,
  output brk_cfg_t         cfg,
  output logic             flag
);
  brk_cfg_t cfg_d;
  logic     flag_d;
  logic     cfg_en;
  logic     flag_en;

  always_comb begin
    cfg_en  = wr_en;
    cfg_d   = brk_cfg_t'(wdata[$bits(brk_cfg_t)-1:0]);
    flag_en = hit | (wr_en & ~wdata[FLAG_BIT]);
    flag_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= CFG_RESET;
      flag <= 1'b0;
    end else begin
      if (cfg_en)  cfg  <= cfg_d;
      if (flag_en) flag <= flag_d;
    end
  end
endmodule

// File: rtl/brk_cond_eval.sv
module brk_cond_eval
  import brk_pkg::*;
(
  input  brk_cfg_t         cfg,
  input  logic             valid,
  input  logic             ifetch,
  input  logic             write,
  input  logic [FLD_W-1:0] size,
  output logic             hit
);
  logic             kind_ok;
  logic             dir_ok;
  logic             size_ok;
  logic [FLD_W-1:0] eff_size;

  always_comb begin
    // cycle kind: bit0 selects fetch, bit1 selects data access
    kind_ok  = ifetch ? cfg.kind[0] : cfg.kind[1];
    // direction: bit0 selects read, bit1 selects write
    dir_ok   = write ? cfg.dir[1] : cfg.dir[0];
    eff_size = ifetch ? SZ_WORD : size;
    size_ok  = (cfg.size == SZ_ANY) || (cfg.size == eff_size);
    hit      = valid & kind_ok & dir_ok & size_ok;
  end
endmodule

// File: rtl/brk_req_gen.sv
module brk_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic irq
);
  logic irq_d;

  always_comb irq_d = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/brk_cycle_match.sv
module brk_cycle_match
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             bus_valid,
  input  logic             bus_ifetch,
  input  logic             bus_write,
  input  logic [FLD_W-1:0] bus_size,
  output logic             brk_irq
);
  brk_cfg_t cfg;
  logic     flag;
  logic     hit;

  brk_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .hit   (hit),
    .cfg   (cfg),
    .flag  (flag)
  );

  brk_cond_eval u_eval (
    .cfg    (cfg),
    .valid  (bus_valid),
    .ifetch (bus_ifetch),
    .write  (bus_write),
    .size   (bus_size),
    .hit    (hit)
  );

  brk_req_gen u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .irq   (brk_irq)
  );

  always_comb cfg_rdata = {flag, 1'b0, cfg};
endmodule

// File: rtl/brk_cycle_match_chk.sv
module brk_cycle_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       bus_valid,
  input logic       bus_ifetch,
  input logic       brk_irq
);
  assert_kind_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[1:0] == 2'b00) |=> !brk_irq);

  assert_dir_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3:2] == 2'b00) |=> !brk_irq);

  assert_fetch_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ifetch && cfg_rdata[4]) |=> !brk_irq);

  assert_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !brk_irq);

  assert_flag_on_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> cfg_rdata[7]);

  assert_rsv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[6]);
endmodule

bind brk_cycle_match brk_cycle_match_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rdata  (cfg_rdata),
  .bus_valid  (bus_valid),
  .bus_ifetch (bus_ifetch),
  .brk_irq    (brk_irq)
);

// File: tb/brk_cycle_match_test.sv
module brk_cycle_match_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       bus_valid;
  logic       bus_ifetch;
  logic       bus_write;
  logic [1:0] bus_size;
  logic       brk_irq;

  int n_chk  = 0;
  int n_fail = 0;

  logic [5:0] m_cfg;
  logic       m_flag;

  always #2 clk = ~clk;   // 250 MHz

  brk_cycle_match uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_valid(bus_valid), .bus_ifetch(bus_ifetch),
    .bus_write(bus_write), .bus_size(bus_size), .brk_irq(brk_irq)
  );

  function automatic logic exp_hit(logic [5:0] c, logic v, logic f, logic w, logic [1:0] s);
    logic k_ok, d_ok, s_ok;
    logic [1:0] es;
    k_ok = f ? c[0] : c[1];
    d_ok = w ? c[3] : c[2];
    es   = f ? 2'b10 : s;
    s_ok = (c[5:4] == 2'b00) || (c[5:4] == es);
    return v && k_ok && d_ok && s_ok;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, model the edge, check at the next negedge.
  task automatic step(string tag, logic wr, logic [7:0] wd,
                      logic v, logic f, logic w, logic [1:0] s);
    logic h;
    cfg_wr = wr; cfg_wdata = wd;
    bus_valid = v; bus_ifetch = f; bus_write = w; bus_size = s;
    h = exp_hit(m_cfg, v, f, w, s);
    if (wr) m_cfg = wd[5:0];
    if (h) m_flag = 1'b1;
    else if (wr && !wd[7]) m_flag = 1'b0;
    @(negedge clk);
    check({tag, " irq"}, {7'b0, brk_irq}, {7'b0, h});
    check({tag, " reg"}, cfg_rdata, {m_flag, 1'b0, m_cfg});
    cfg_wr = 1'b0; bus_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    bus_valid = 1'b0; bus_ifetch = 1'b0; bus_write = 1'b0; bus_size = 2'b00;
    m_cfg = 6'h0C; m_flag = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset reg", cfg_rdata, 8'h0C);
    check("R1 reset irq", {7'b0, brk_irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset kind 00 blocks everything
    step("R2 kind off", 0, 0, 1, 1, 0, 2'b10);
    step("R2 kind off data", 0, 0, 1, 0, 1, 2'b01);
    // R5: fetch only, read, word; bus shows longword
    step("R9 write", 1, 8'h25, 0, 0, 0, 0);
    step("R5 fetch long as word", 0, 0, 1, 1, 0, 2'b11);
    step("R2 fetch-only rejects data", 0, 0, 1, 0, 0, 2'b10);
    step("R5 fetch size byte", 1, 8'h15, 0, 0, 0, 0);
    step("R5 fetch never byte", 0, 0, 1, 1, 0, 2'b10);
    step("R5 fetch size long", 1, 8'h35, 0, 0, 0, 0);
    step("R5 fetch never long", 0, 0, 1, 1, 0, 2'b11);
    // R6: data access, write, byte
    step("R9 write data", 1, 8'h1A, 0, 0, 0, 0);
    step("R6 data byte hit", 0, 0, 1, 0, 1, 2'b01);
    step("R6 data long miss", 0, 0, 1, 0, 1, 2'b11);
    step("R3 read rejected", 0, 0, 1, 0, 0, 2'b01);
    // R3: dir 00 blocks
    step("R3 dir off", 1, 8'h83, 0, 0, 0, 0);
    step("R3 dir off read", 0, 0, 1, 0, 0, 2'b01);
    step("R3 dir off write", 0, 0, 1, 1, 1, 2'b10);
    // R4: size ignored
    step("R4 size any", 1, 8'h8F, 0, 0, 0, 0);
    step("R4 size any long", 0, 0, 1, 0, 1, 2'b11);
    step("R4 size any byte", 0, 0, 1, 1, 0, 2'b01);
    // R7: no strobe, no request
    step("R7 no strobe", 0, 0, 0, 0, 0, 2'b01);
    // R8: write 1 keeps flag, write 0 clears, set wins
    step("R8 write one keeps", 1, 8'h8F, 0, 0, 0, 0);
    step("R8 write zero clears", 1, 8'h0F, 0, 0, 0, 0);
    step("R8 hit beats clear", 1, 8'h0F, 1, 0, 0, 2'b10);
    // R9: write and bus at same edge uses old settings
    step("R9 same edge old", 1, 8'h00, 1, 0, 0, 2'b10);
    step("R9 next edge new", 0, 0, 1, 0, 0, 2'b10);
    // R10: bit 6 ignores writes
    step("R10 rsv bit", 1, 8'h7F, 0, 0, 0, 0);
    // R7: random mix
    for (int i = 0; i < 3000; i++) begin
      step("R7 random", ($urandom % 4) == 0, 8'($urandom),
           ($urandom % 3) != 0, 1'($urandom), 1'($urandom), 2'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule